// File: doc/BRIEF.md
# Double-Data-Rate Ethernet Transmit Adapter

This block sits between a MAC that produces one byte per transmit clock and a PHY that expects the reduced, double-data-rate transmit link. On each rising edge it captures the byte, the enable and the error flag. During the following clock period it drives a 4-bit data bus and a single control line that change on both clock edges. The transmit clock itself is forwarded to the PHY. In gigabit mode the byte is split into two nibbles across the two edges. In the 100 Mb and 10 Mb modes only the low nibble is meaningful, so it is repeated on both edges.

The one control line is time-shared. In the high phase of the clock it carries the enable. In the low phase it carries the enable XOR-ed with the error flag. An idle cycle, with neither enable nor error set, drives all pins low on both edges. The DDR pin behaviour is built from two rising-edge registers followed by a clock-level select, so no vendor output primitive is needed. Clock delay and skew tuning are left to the surrounding I/O logic.

Top module: `tx_ddr_adapter`

## Requirements
- R1: While the clock is high, `txd_o` shows bits [3:0] of the byte captured at that clock period's rising edge, whenever enable or error was set.
- R2: In gigabit mode (`speed_i` = 2 or 3), `txd_o` shows bits [7:4] of the same byte while the clock is low.
- R3: While the clock is high, `txctl_o` equals the captured enable.
- R4: While the clock is low, `txctl_o` equals the captured enable XOR the captured error flag.
- R5: In the 100 Mb mode (`speed_i` = 1) and the 10 Mb mode (`speed_i` = 0), bits [3:0] of the captured byte appear on `txd_o` in both clock phases, and bits [7:4] have no effect.
- R6: A cycle captured with enable low and error low drives `txd_o` and `txctl_o` to zero in both phases, whatever the data byte.
- R7: A synchronous active-high reset, sampled at a rising edge, drives `txd_o` and `txctl_o` to zero in both phases of the following clock period.
- R8: Inputs captured at rising edge N appear on the pins in the high phase after edge N and the low phase that follows it, and in no other period.
- R9: `txclk_o` follows `clk` in both phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC transmit clock (125, 25 or 2.5 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| speed_i | input | 2 | Speed select: 0 = 10 Mb, 1 = 100 Mb, 2 or 3 = gigabit |
| data_i | input | 8 | Transmit byte from the MAC |
| en_i | input | 1 | Transmit enable from the MAC |
| err_i | input | 1 | Transmit error from the MAC |
| txclk_o | output | 1 | Forwarded transmit clock toward the PHY |
| txd_o | output | 4 | DDR transmit data toward the PHY |
| txctl_o | output | 1 | DDR control line: enable when high, enable XOR error when low |

## Verification
Each result is due one register stage after its stimulus. A byte, enable and error set up before rising edge N appear in the high phase that edge opens and in the low phase that comes next. The driver stamps each expected item with the index of the rising edge that captures it. The monitor samples the pins 2 ns into the high phase and 2 ns into the low phase. It compares an item only when the current edge index matches the item's stamp, so no result is judged a period early or late. Reset is checked the same way, at the period that follows the reset edge.

// File: rtl/tx_ddr_pkg.sv
package tx_ddr_pkg;

   typedef enum logic [1:0] {
      SPD_10M   = 2'd0,
      SPD_100M  = 2'd1,
      SPD_1G    = 2'd2,
      SPD_1G_RS = 2'd3
   } speed_e;

   function automatic logic speed_is_wide(input logic [1:0] spd);
      return spd[1];
   endfunction

endpackage

// File: rtl/tx_half_capture.sv
module tx_half_capture #(
   parameter int NIBBLE_W = 4,
   parameter bit CTL_XOR  = 1'b1,
   localparam int BYTE_W  = 2 * NIBBLE_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [1:0]          speed_i,
   input  logic [BYTE_W-1:0]   data_i,
   input  logic                en_i,
   input  logic                err_i,
   output logic [NIBBLE_W-1:0] rise_nib_o,
   output logic [NIBBLE_W-1:0] fall_nib_o,
   output logic                rise_ctl_o,
   output logic                fall_ctl_o
);
   import tx_ddr_pkg::*;

   logic                active;
   logic                wide;
   logic [NIBBLE_W-1:0] lo_nib;
   logic [NIBBLE_W-1:0] hi_nib;
   logic [NIBBLE_W-1:0] fall_src;
   logic                fall_ctl_src;

   assign active = en_i | err_i;
   assign wide   = speed_is_wide(speed_i);
   assign lo_nib = data_i[NIBBLE_W-1:0];
   assign hi_nib = data_i[BYTE_W-1:NIBBLE_W];

   always_comb begin
      fall_src = wide ? hi_nib : lo_nib;
   end

   generate
      if (CTL_XOR) begin : g_ctl_xor
         assign fall_ctl_src = en_i ^ err_i;
      end else begin : g_ctl_plain
         assign fall_ctl_src = err_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         rise_nib_o <= '0;
         fall_nib_o <= '0;
         rise_ctl_o <= 1'b0;
         fall_ctl_o <= 1'b0;
      end else if (!active) begin
         rise_nib_o <= '0;
         fall_nib_o <= '0;
         rise_ctl_o <= 1'b0;
         fall_ctl_o <= 1'b0;
      end else begin
         rise_nib_o <= lo_nib;
         fall_nib_o <= fall_src;
         rise_ctl_o <= en_i;
         fall_ctl_o <= fall_ctl_src;
      end
   end

endmodule

// File: rtl/tx_edge_mux.sv
module tx_edge_mux #(
   parameter int W = 5
) (
   input  logic         phase_i,
   input  logic [W-1:0] hi_i,
   input  logic [W-1:0] lo_i,
   output logic [W-1:0] pin_o
);
   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign pin_o[b] = phase_i ? hi_i[b] : lo_i[b];
      end
   endgenerate

endmodule

// File: rtl/tx_ddr_adapter.sv
module tx_ddr_adapter #(
   parameter int NIBBLE_W = 4,
   parameter bit CTL_XOR  = 1'b1,
   localparam int BYTE_W  = 2 * NIBBLE_W,
   localparam int LANE_W  = NIBBLE_W + 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [1:0]          speed_i,
   input  logic [BYTE_W-1:0]   data_i,
   input  logic                en_i,
   input  logic                err_i,
   output logic                txclk_o,
   output logic [NIBBLE_W-1:0] txd_o,
   output logic                txctl_o
);
   generate
      if (NIBBLE_W < 1) begin : g_bad_width
         $error("NIBBLE_W must be at least 1");
      end
   endgenerate

   logic [NIBBLE_W-1:0] rise_nib;
   logic [NIBBLE_W-1:0] fall_nib;
   logic                rise_ctl;
   logic                fall_ctl;
   logic [LANE_W-1:0]   lane;

   tx_half_capture #(
      .NIBBLE_W (NIBBLE_W),
      .CTL_XOR  (CTL_XOR)
   ) u_capture (
      .clk        (clk),
      .rst        (rst),
      .speed_i    (speed_i),
      .data_i     (data_i),
      .en_i       (en_i),
      .err_i      (err_i),
      .rise_nib_o (rise_nib),
      .fall_nib_o (fall_nib),
      .rise_ctl_o (rise_ctl),
      .fall_ctl_o (fall_ctl)
   );

   tx_edge_mux #(
      .W (LANE_W)
   ) u_edge_mux (
      .phase_i (clk),
      .hi_i    ({rise_ctl, rise_nib}),
      .lo_i    ({fall_ctl, fall_nib}),
      .pin_o   (lane)
   );

   assign txclk_o = clk;
   assign txd_o   = lane[NIBBLE_W-1:0];
   assign txctl_o = lane[LANE_W-1];

endmodule

// File: rtl/tx_ddr_adapter_chk.sv
module tx_ddr_adapter_chk #(
   parameter int NIBBLE_W = 4,
   localparam int BYTE_W  = 2 * NIBBLE_W
) (
   input logic                clk,
   input logic                rst,
   input logic [1:0]          speed_i,
   input logic [BYTE_W-1:0]   data_i,
   input logic                en_i,
   input logic                err_i,
   input logic [NIBBLE_W-1:0] rise_nib,
   input logic [NIBBLE_W-1:0] fall_nib,
   input logic                rise_ctl,
   input logic                fall_ctl
);
   logic past_ok = 1'b0;
   logic rst_q   = 1'b0;

   always_ff @(posedge clk) begin
      past_ok <= 1'b1;
      rst_q   <= rst;
   end

   always_ff @(posedge clk) begin
      if (past_ok && rst_q)
         AST_RESET_CLEAR: assert (rise_nib == '0 && fall_nib == '0 && !rise_ctl && !fall_ctl); // R7
   end

   AST_LOW_NIBBLE_RISE: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(rst) && ($past(en_i) || $past(err_i))) |-> rise_nib == $past(data_i[NIBBLE_W-1:0])); // R1

   AST_HIGH_NIBBLE_FALL: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(rst) && ($past(en_i) || $past(err_i)) && $past(speed_i[1]))
      |-> fall_nib == $past(data_i[BYTE_W-1:NIBBLE_W])); // R2

   AST_CTL_ENABLE: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(rst)) |-> rise_ctl == $past(en_i)); // R3

   AST_CTL_ERROR: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(rst)) |-> fall_ctl == ($past(en_i) ^ $past(err_i))); // R4

   AST_SLOW_REPEAT: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(rst) && !$past(speed_i[1])) |-> fall_nib == rise_nib); // R5

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(rst) && !$past(en_i) && !$past(err_i))
      |-> (rise_nib == '0 && fall_nib == '0 && !rise_ctl && !fall_ctl)); // R6

endmodule

bind tx_ddr_adapter tx_ddr_adapter_chk #(.NIBBLE_W(NIBBLE_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .speed_i  (speed_i),
   .data_i   (data_i),
   .en_i     (en_i),
   .err_i    (err_i),
   .rise_nib (rise_nib),
   .fall_nib (fall_nib),
   .rise_ctl (rise_ctl),
   .fall_ctl (fall_ctl)
);

// File: tb/test_tx_ddr_adapter.sv
`timescale 1ns/1ps
module test_tx_ddr_adapter;

   typedef struct {
      int         due;
      logic [3:0] d_hi;
      logic       c_hi;
      logic [3:0] d_lo;
      logic       c_lo;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] speed_i = 2'd2;
   logic [7:0] data_i = 8'h00;
   logic       en_i = 1'b0;
   logic       err_i = 1'b0;
   logic       txclk_o;
   logic [3:0] txd_o;
   logic       txctl_o;

   int   cyc = 0;
   int   n_checks = 0;
   int   n_fail = 0;
   exp_t exp_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tx_ddr_adapter i_tx_ddr_adapter (
      .clk     (clk),
      .rst     (rst),
      .speed_i (speed_i),
      .data_i  (data_i),
      .en_i    (en_i),
      .err_i   (err_i),
      .txclk_o (txclk_o),
      .txd_o   (txd_o),
      .txctl_o (txctl_o)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Driver: applies one capture's worth of stimulus and queues the expected pins.
   task automatic drive(input logic r, input logic [1:0] spd, input logic [7:0] d,
                        input logic en, input logic err, input string tag);
      exp_t e;
      @(negedge clk);
      #1;
      rst = r; speed_i = spd; data_i = d; en_i = en; err_i = err;
      e.due = cyc + 1;
      e.tag = tag;
      if (r || (!en && !err)) begin
         e.d_hi = 4'h0; e.d_lo = 4'h0; e.c_hi = 1'b0; e.c_lo = 1'b0;
      end else begin
         e.d_hi = d[3:0];
         e.d_lo = spd[1] ? d[7:4] : d[3:0];
         e.c_hi = en;
         e.c_lo = en ^ err;
      end
      exp_q.push_back(e);
   endtask

   // Monitor: samples both phases of each period and checks the item due then.
   initial begin
      logic [3:0] d_hi, d_lo;
      logic       c_hi, c_lo, k_hi, k_lo;
      exp_t       e;
      forever begin
         @(posedge clk);
         #2;
         d_hi = txd_o; c_hi = txctl_o; k_hi = txclk_o;
         @(negedge clk);
         #2;
         d_lo = txd_o; c_lo = txctl_o; k_lo = txclk_o;
         if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            e = exp_q.pop_front();
            check({e.tag, " R1/R8 data high phase"}, {4'h0, d_hi}, {4'h0, e.d_hi});
            check({e.tag, " R2/R5 data low phase"},  {4'h0, d_lo}, {4'h0, e.d_lo});
            check({e.tag, " R3 ctl high phase"},     {7'h0, c_hi}, {7'h0, e.c_hi});
            check({e.tag, " R4 ctl low phase"},      {7'h0, c_lo}, {7'h0, e.c_lo});
            check("R9 forwarded clock", {6'h0, k_hi, k_lo}, 8'h02);
         end
      end
   end

   initial begin
      #(200000 * 8);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      // R7: reset held with live inputs must give zeros
      drive(1'b1, 2'd2, 8'hFF, 1'b1, 1'b1, "R7 reset");
      drive(1'b1, 2'd1, 8'hA5, 1'b1, 1'b0, "R7 reset");
      // Gigabit splitting: R1 R2 R3 R4
      drive(1'b0, 2'd2, 8'h5A, 1'b1, 1'b0, "gig");
      drive(1'b0, 2'd2, 8'hC3, 1'b1, 1'b0, "gig");
      drive(1'b0, 2'd3, 8'h96, 1'b1, 1'b0, "gig code3");
      drive(1'b0, 2'd2, 8'hE7, 1'b1, 1'b1, "R4 error during frame");
      drive(1'b0, 2'd2, 8'h0F, 1'b0, 1'b1, "R4 error without enable");
      // R6 idle with non-zero data
      drive(1'b0, 2'd2, 8'hFF, 1'b0, 1'b0, "R6 idle");
      drive(1'b0, 2'd1, 8'h7E, 1'b0, 1'b0, "R6 idle slow");
      // R5 slow modes repeat low nibble
      drive(1'b0, 2'd1, 8'hB4, 1'b1, 1'b0, "R5 100M");
      drive(1'b0, 2'd0, 8'h3D, 1'b1, 1'b0, "R5 10M");
      drive(1'b0, 2'd0, 8'h82, 1'b1, 1'b1, "R5 10M error");
      drive(1'b0, 2'd1, 8'hF1, 1'b0, 1'b1, "R5 100M ctl error only");
      // R8 back-to-back changing bytes
      for (int i = 0; i < 16; i++)
         drive(1'b0, 2'((i / 4) % 4), 8'(i * 37 + 11), i % 5 != 4, i % 7 == 3, "R8 stream");
      // R7 mid-stream reset
      drive(1'b1, 2'd2, 8'h69, 1'b1, 1'b0, "R7 mid reset");
      drive(1'b0, 2'd2, 8'h69, 1'b1, 1'b0, "after reset");
      drive(1'b0, 2'd2, 8'h00, 1'b0, 1'b0, "R6 final idle");
      repeat (3) @(negedge clk);
      check("R8 all results produced", 8'(exp_q.size()), 8'h00);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule